// File: doc/BRIEF.md
# Block Upload Command Sequencer

This block runs the command side of a session that moves a program into local memory in fixed 1 KiB blocks. It receives one decoded command frame at a time as a byte-parallel word. The word holds an opcode byte, a sub-function byte and five parameter bytes, and it comes with a single-cycle valid strobe. The block checks every frame against fixed parameter rules and against a set of session flags. Frames that pass change the session state and produce a response frame one cycle later. Frames that fail are dropped without a trace.

The block keeps the session flags, a countdown of the blocks still to be delivered, the base address of the block being written, and the expected checksum. A separate data writer reads `data_en` and `tgt_base`, and it reports a full block on `blk_full`. A separate unit computes the checksum and supplies it on `calc_sum`. When the verify command sees a matching checksum, the block raises `exec_go` and points `tgt_base` at the start of the program region. When the checksum does not match, the block raises `sum_fail` and withdraws permission to verify. A watchdog expiry from outside returns everything to the locked idle state.

Top module: `upl_seq_top`

## Requirements
- R1: After reset `rsp_valid`, `exec_go`, `sum_fail` and `data_en` are low and `tgt_base` is 0.
- R2: Open (opcode 0x31, sub 0xA0) with parameter bytes P1..P5 = 00, n, 00, 01 and n <= N_BLK is accepted from any state. It loads the block counter with n and starts the session. One cycle later it replies 7F 31 A0 n 00 00. `rsp_data[47:40]` carries the first response byte, and `frm_par[39:32]` carries P1.
- R3: Open with n > N_BLK, or with any other fixed byte wrong, gives no reply and does not start a session.
- R4: Set-address (0x34, 0x80) needs a started session, P1P2 = 0x0400, P3 = 0x0B, P5 = 0x00 and P4 a multiple of 4 no larger than 4*(N_BLK-1). When accepted, it replies 7F 34 80 04 00 00, sets `tgt_base` to {P3,P4,P5}, raises `data_en` and marks an address as pending.
- R5: Set-address with P4 off-grid or above the limit, or with a wrong length, gives no reply and leaves `tgt_base` unchanged.
- R6: A `blk_full` pulse while `data_en` is high drops `data_en` on the next cycle.
- R7: Finalize (0x37, 0x80) is accepted only while an address is pending. It clears the pending mark and replies 7F 37 80 00 00 00.
- R8: Block-done (0x32, 0xA2) is accepted only in a started session, with no address pending and a non-zero counter. It replies 7F 32 A2 00 00 00 and decrements the counter. When the counter reaches zero it sets the all-blocks flag.
- R9: Checksum submit (0x31, 0xA5) is accepted only with the all-blocks flag set. It latches {P1,P2} as the expected value and replies 7F 31 A5 P1 P2 00.
- R10: Verify (0x32, 0xA5) with the all-blocks flag set and `calc_sum` equal to the expected value replies 7F 32 A5 00 00 00. In the same cycle it pulses `exec_go` and sets `tgt_base` to 0x0B0000, and it returns the session to locked idle.
- R11: Verify on a mismatch replies 7F 32 A5 00 5B 63, pulses `sum_fail` and clears the all-blocks flag, so that a second verify is rejected.
- R12: `wdog_expire` clears every flag, the counter and `tgt_base`, and it overrides a frame presented in the same cycle.
- R13: A frame with an unknown opcode or sub-function, or a cycle with no frame, produces no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame strobe, one cycle per frame |
| frm_op | input | 8 | Opcode byte |
| frm_sub | input | 8 | Sub-function byte |
| frm_par | input | 40 | Parameter bytes P1 (MSB) to P5 (LSB) |
| calc_sum | input | 16 | Checksum computed over the uploaded region |
| blk_full | input | 1 | Data writer has filled the current block |
| wdog_expire | input | 1 | Session timeout from outside |
| rsp_valid | output | 1 | Response frame strobe |
| rsp_data | output | 48 | Response bytes, first byte in the MSB |
| tgt_base | output | 24 | Base address for the data writer, and the jump target after a pass |
| data_en | output | 1 | Data frames are allowed |
| exec_go | output | 1 | Checksum passed, start execution |
| sum_fail | output | 1 | Checksum mismatch |

## Verification
The bench builds the block with its default values: N_BLK = 5 and an address high byte of 0x0B. With these values the full five-block countdown is reachable, along with every legal middle address byte from 0x00 to 0x10. The first illegal byte above the grid, 0x14, and an open request for six blocks sit exactly on the rejection boundaries. A second short session of one block reaches the counter-at-zero rejection, the checksum mismatch path and the watchdog override in only a few frames.

// File: rtl/upl_seq_pkg.sv
package upl_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int PAR_N  = 5;
    localparam int RSP_N  = 6;
    localparam int ADDR_W = 24;
    localparam int SUM_W  = 16;

    localparam logic [7:0] OP_OPEN = 8'h31;
    localparam logic [7:0] OP_DONE = 8'h32;
    localparam logic [7:0] OP_ADDR = 8'h34;
    localparam logic [7:0] OP_FIN  = 8'h37;

    localparam logic [7:0] SF_INIT = 8'hA0;
    localparam logic [7:0] SF_BLK  = 8'hA2;
    localparam logic [7:0] SF_SUM  = 8'hA5;
    localparam logic [7:0] SF_80   = 8'h80;

    localparam logic [7:0]  RSP_TAG   = 8'h7F;
    localparam logic [15:0] FAIL_CODE = 16'h5B63;
    localparam logic [15:0] BLK_LEN   = 16'h0400;
    localparam int          BLK_STEP  = 4;

    typedef enum logic [2:0] {
        K_NONE, K_INIT, K_ADDR, K_FIN, K_BDONE, K_SUMLD, K_VERIFY
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  par_ok;
    } dec_t;

    typedef struct packed {
        logic started;
        logic data_done;
        logic addr_pend;
        logic all_blk;
    } flags_t;

    localparam flags_t FLAGS_IDLE = '{started: 1'b0, data_done: 1'b1,
                                      addr_pend: 1'b0, all_blk: 1'b0};

    function automatic kind_e classify(input logic [7:0] op, input logic [7:0] sub);
        kind_e k;
        k = K_NONE;
        unique case ({op, sub})
            {OP_OPEN, SF_INIT}: k = K_INIT;
            {OP_ADDR, SF_80}:   k = K_ADDR;
            {OP_FIN,  SF_80}:   k = K_FIN;
            {OP_DONE, SF_BLK}:  k = K_BDONE;
            {OP_OPEN, SF_SUM}:  k = K_SUMLD;
            {OP_DONE, SF_SUM}:  k = K_VERIFY;
            default:            k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [7:0] par_byte(input logic [PAR_N*BYTE_W-1:0] par, input int idx);
        return par[(PAR_N-1-idx)*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/upl_cmd_dec.sv
module upl_cmd_dec
    import upl_seq_pkg::*;
#(
    parameter int         N_BLK   = 5,
    parameter logic [7:0] ADDR_HI = 8'h0B
) (
    input  logic [BYTE_W-1:0]       frm_op,
    input  logic [BYTE_W-1:0]       frm_sub,
    input  logic [PAR_N*BYTE_W-1:0] frm_par,
    output dec_t                    dec
);
    localparam logic [7:0] MID_MAX = 8'((N_BLK - 1) * BLK_STEP);
    localparam logic [7:0] N_MAX   = 8'(N_BLK);

    logic [BYTE_W-1:0] pb [PAR_N];

    for (genvar g = 0; g < PAR_N; g++) begin : g_unpack
        assign pb[g] = par_byte(frm_par, g);
    end

    logic init_ok;
    logic addr_ok;

    assign init_ok = (pb[0] == 8'h00) && (pb[1] <= N_MAX) &&
                     (pb[2] == 8'h00) && (pb[3] == 8'h01);

    assign addr_ok = ({pb[0], pb[1]} == BLK_LEN) && (pb[2] == ADDR_HI) &&
                     (pb[4] == 8'h00) && ((pb[3] % BLK_STEP) == 0) &&
                     (pb[3] <= MID_MAX);

    always_comb begin
        dec.kind = classify(frm_op, frm_sub);
        unique case (dec.kind)
            K_INIT:  dec.par_ok = init_ok;
            K_ADDR:  dec.par_ok = addr_ok;
            K_NONE:  dec.par_ok = 1'b0;
            default: dec.par_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/upl_sess_state.sv
module upl_sess_state
    import upl_seq_pkg::*;
#(
    parameter int         N_BLK   = 5,
    parameter int         CNT_W   = 3,
    parameter logic [7:0] ADDR_HI = 8'h0B
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frm_valid,
    input  logic                    wdog_expire,
    input  logic                    blk_full,
    input  dec_t                    dec,
    input  logic [PAR_N*BYTE_W-1:0] frm_par,
    input  logic [SUM_W-1:0]        calc_sum,
    output logic                    accept,
    output logic                    sum_match,
    output flags_t                  flg,
    output logic [ADDR_W-1:0]       tgt_base
);
    logic [CNT_W-1:0] blk_cnt;
    logic [SUM_W-1:0] exp_sum;
    logic             gate;

    always_comb begin
        unique case (dec.kind)
            K_INIT:   gate = 1'b1;
            K_ADDR:   gate = flg.started;
            K_FIN:    gate = flg.started && flg.addr_pend;
            K_BDONE:  gate = flg.started && !flg.addr_pend && (blk_cnt != '0);
            K_SUMLD:  gate = flg.all_blk;
            K_VERIFY: gate = flg.all_blk;
            default:  gate = 1'b0;
        endcase
    end

    assign accept    = frm_valid && !wdog_expire && dec.par_ok && gate;
    assign sum_match = (exp_sum == calc_sum);

    always_ff @(posedge clk) begin
        if (rst || wdog_expire) begin
            flg      <= FLAGS_IDLE;
            blk_cnt  <= '0;
            exp_sum  <= '0;
            tgt_base <= '0;
        end else begin
            if (blk_full && flg.started && !flg.data_done) begin
                flg.data_done <= 1'b1;
            end
            if (accept) begin
                unique case (dec.kind)
                    K_INIT: begin
                        flg         <= FLAGS_IDLE;
                        flg.started <= 1'b1;
                        blk_cnt     <= par_byte(frm_par, 1)[CNT_W-1:0];
                    end
                    K_ADDR: begin
                        flg.data_done <= 1'b0;
                        flg.addr_pend <= 1'b1;
                        tgt_base      <= {par_byte(frm_par, 2), par_byte(frm_par, 3),
                                          par_byte(frm_par, 4)};
                    end
                    K_FIN: begin
                        flg.addr_pend <= 1'b0;
                    end
                    K_BDONE: begin
                        blk_cnt <= blk_cnt - 1'b1;
                        if (blk_cnt == CNT_W'(1)) begin
                            flg.all_blk <= 1'b1;
                        end
                    end
                    K_SUMLD: begin
                        exp_sum <= {par_byte(frm_par, 0), par_byte(frm_par, 1)};
                    end
                    K_VERIFY: begin
                        if (sum_match) begin
                            flg      <= FLAGS_IDLE;
                            blk_cnt  <= '0;
                            tgt_base <= {ADDR_HI, 16'h0000};
                        end else begin
                            flg.all_blk <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/upl_resp_fmt.sv
module upl_resp_fmt
    import upl_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  kind_e                   kind,
    input  logic                    sum_match,
    input  logic [PAR_N*BYTE_W-1:0] frm_par,
    output logic                    rsp_valid,
    output logic [RSP_N*BYTE_W-1:0] rsp_data,
    output logic                    exec_go,
    output logic                    sum_fail
);
    logic [RSP_N*BYTE_W-1:0] body;
    logic [7:0]              p1;
    logic [7:0]              p2;

    assign p1 = par_byte(frm_par, 0);
    assign p2 = par_byte(frm_par, 1);

    always_comb begin
        unique case (kind)
            K_INIT:   body = {RSP_TAG, OP_OPEN, SF_INIT, p2, 16'h0000};
            K_ADDR:   body = {RSP_TAG, OP_ADDR, SF_80, p1, p2, 8'h00};
            K_FIN:    body = {RSP_TAG, OP_FIN, SF_80, 24'h000000};
            K_BDONE:  body = {RSP_TAG, OP_DONE, SF_BLK, 24'h000000};
            K_SUMLD:  body = {RSP_TAG, OP_OPEN, SF_SUM, p1, p2, 8'h00};
            K_VERIFY: body = sum_match ? {RSP_TAG, OP_DONE, SF_SUM, 24'h000000}
                                       : {RSP_TAG, OP_DONE, SF_SUM, 8'h00, FAIL_CODE};
            default:  body = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            exec_go   <= 1'b0;
            sum_fail  <= 1'b0;
        end else begin
            rsp_valid <= accept;
            exec_go   <= accept && (kind == K_VERIFY) && sum_match;
            sum_fail  <= accept && (kind == K_VERIFY) && !sum_match;
            if (accept) begin
                rsp_data <= body;
            end
        end
    end

endmodule

// File: rtl/upl_seq_top.sv
module upl_seq_top
    import upl_seq_pkg::*;
#(
    parameter int         N_BLK   = 5,
    parameter logic [7:0] ADDR_HI = 8'h0B
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frm_valid,
    input  logic [BYTE_W-1:0]       frm_op,
    input  logic [BYTE_W-1:0]       frm_sub,
    input  logic [PAR_N*BYTE_W-1:0] frm_par,
    input  logic [SUM_W-1:0]        calc_sum,
    input  logic                    blk_full,
    input  logic                    wdog_expire,
    output logic                    rsp_valid,
    output logic [RSP_N*BYTE_W-1:0] rsp_data,
    output logic [ADDR_W-1:0]       tgt_base,
    output logic                    data_en,
    output logic                    exec_go,
    output logic                    sum_fail
);
    localparam int CNT_W = $clog2(N_BLK + 1);

    dec_t   dec;
    flags_t flg;
    logic   accept;
    logic   sum_match;

    upl_cmd_dec #(.N_BLK(N_BLK), .ADDR_HI(ADDR_HI)) i_dec (
        .frm_op  (frm_op),
        .frm_sub (frm_sub),
        .frm_par (frm_par),
        .dec     (dec)
    );

    upl_sess_state #(.N_BLK(N_BLK), .CNT_W(CNT_W), .ADDR_HI(ADDR_HI)) i_state (
        .clk         (clk),
        .rst         (rst),
        .frm_valid   (frm_valid),
        .wdog_expire (wdog_expire),
        .blk_full    (blk_full),
        .dec         (dec),
        .frm_par     (frm_par),
        .calc_sum    (calc_sum),
        .accept      (accept),
        .sum_match   (sum_match),
        .flg         (flg),
        .tgt_base    (tgt_base)
    );

    upl_resp_fmt i_fmt (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .kind      (dec.kind),
        .sum_match (sum_match),
        .frm_par   (frm_par),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .exec_go   (exec_go),
        .sum_fail  (sum_fail)
    );

    assign data_en = flg.started && !flg.data_done;

endmodule

// File: rtl/upl_seq_chk.sv
module upl_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        frm_valid,
    input logic [7:0]  frm_op,
    input logic [7:0]  frm_sub,
    input logic [39:0] frm_par,
    input logic [15:0] calc_sum,
    input logic        blk_full,
    input logic        wdog_expire,
    input logic        rsp_valid,
    input logic [47:0] rsp_data,
    input logic [23:0] tgt_base,
    input logic        data_en,
    input logic        exec_go,
    input logic        sum_fail
);
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !rsp_valid);

    a_r12_wdog_clears: assert property (@(posedge clk) disable iff (rst)
        wdog_expire |=> (!rsp_valid && !data_en && tgt_base == 24'h0));

    a_r10_go_reply: assert property (@(posedge clk) disable iff (rst)
        exec_go |-> (rsp_valid && rsp_data == 48'h7F32A5000000));

    a_r10_go_base: assert property (@(posedge clk) disable iff (rst)
        exec_go |-> (tgt_base == 24'h0B0000 && !data_en));

    a_r11_fail_reply: assert property (@(posedge clk) disable iff (rst)
        sum_fail |-> (rsp_valid && rsp_data == 48'h7F32A5005B63 && !exec_go));

    a_r4_addr_base: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data[39:24] == 16'h3480) |->
            (tgt_base[23:16] == 8'h0B && tgt_base[7:0] == 8'h00 && data_en));

endmodule

bind upl_seq_top upl_seq_chk i_chk (.*);

// File: tb/test_upl_seq_top.sv
module test_upl_seq_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm_valid;
    logic [7:0]  frm_op;
    logic [7:0]  frm_sub;
    logic [39:0] frm_par;
    logic [15:0] calc_sum;
    logic        blk_full;
    logic        wdog_expire;
    logic        rsp_valid;
    logic [47:0] rsp_data;
    logic [23:0] tgt_base;
    logic        data_en;
    logic        exec_go;
    logic        sum_fail;

    always #2.5 clk = ~clk;

    upl_seq_top i_upl_seq_top (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        got_v;
    logic [47:0] got_rsp;
    logic        got_go;
    logic        got_fail;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  sub;
        logic [39:0] par;
        logic [15:0] calc;
        logic        ok;
        logic [47:0] rsp;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{8'h31, 8'hA0, 40'h0006000100, 16'h0, 1'b0, 48'h0},            // R3 n too big
        '{8'h34, 8'h80, 40'h04000B0000, 16'h0, 1'b0, 48'h0},            // R4 no session
        '{8'h31, 8'hA0, 40'h0005000100, 16'h0, 1'b1, 48'h7F31A0050000}, // R2
        '{8'h37, 8'h80, 40'h0, 16'h0, 1'b0, 48'h0},                     // R7 nothing pending
        '{8'h34, 8'h80, 40'h04000B1400, 16'h0, 1'b0, 48'h0},            // R5 above grid
        '{8'h34, 8'h80, 40'h03000B0000, 16'h0, 1'b0, 48'h0},            // R5 bad length
        '{8'h34, 8'h80, 40'h04000B0000, 16'h0, 1'b1, 48'h7F3480040000}, // R4
        '{8'h32, 8'hA2, 40'h0, 16'h0, 1'b0, 48'h0},                     // R8 pending
        '{8'h37, 8'h80, 40'h0, 16'h0, 1'b1, 48'h7F3780000000},          // R7
        '{8'h32, 8'hA2, 40'h0, 16'h0, 1'b1, 48'h7F32A2000000},          // R8
        '{8'h31, 8'hA5, 40'h1234000000, 16'h0, 1'b0, 48'h0},            // R9 early
        '{8'h34, 8'h80, 40'h04000B0400, 16'h0, 1'b1, 48'h7F3480040000},
        '{8'h37, 8'h80, 40'h0, 16'h0, 1'b1, 48'h7F3780000000},
        '{8'h32, 8'hA2, 40'h0, 16'h0, 1'b1, 48'h7F32A2000000},
        '{8'h34, 8'h80, 40'h04000B0800, 16'h0, 1'b1, 48'h7F3480040000},
        '{8'h37, 8'h80, 40'h0, 16'h0, 1'b1, 48'h7F3780000000},
        '{8'h32, 8'hA2, 40'h0, 16'h0, 1'b1, 48'h7F32A2000000},
        '{8'h34, 8'h80, 40'h04000B0C00, 16'h0, 1'b1, 48'h7F3480040000},
        '{8'h37, 8'h80, 40'h0, 16'h0, 1'b1, 48'h7F3780000000},
        '{8'h32, 8'hA2, 40'h0, 16'h0, 1'b1, 48'h7F32A2000000},
        '{8'h34, 8'h80, 40'h04000B1000, 16'h0, 1'b1, 48'h7F3480040000}, // R4 top of grid
        '{8'h37, 8'h80, 40'h0, 16'h0, 1'b1, 48'h7F3780000000},
        '{8'h32, 8'hA2, 40'h0, 16'h0, 1'b1, 48'h7F32A2000000},          // R8 reaches zero
        '{8'h31, 8'hA5, 40'h1234000000, 16'h0, 1'b1, 48'h7F31A5123400}, // R9
        '{8'h32, 8'hA5, 40'h0, 16'h1234, 1'b1, 48'h7F32A5000000}        // R10
    };

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [7:0] sub, input logic [39:0] par,
                        input logic [15:0] calc, input logic wd);
        @(negedge clk);
        frm_valid   = 1'b1;
        frm_op      = op;
        frm_sub     = sub;
        frm_par     = par;
        calc_sum    = calc;
        wdog_expire = wd;
        @(negedge clk);
        frm_valid   = 1'b0;
        wdog_expire = 1'b0;
        got_v    = rsp_valid;
        got_rsp  = rsp_data;
        got_go   = exec_go;
        got_fail = sum_fail;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        rst = 1'b1; frm_valid = 1'b0; frm_op = '0; frm_sub = '0; frm_par = '0;
        calc_sum = '0; blk_full = 1'b0; wdog_expire = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!rsp_valid && !exec_go && !sum_fail, "R1", "strobes", {rsp_valid, exec_go, sum_fail}, 0);
        check(!data_en, "R1", "data_en", data_en, 0);
        check(tgt_base == 24'h0, "R1", "tgt_base", tgt_base, 0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].op, VEC[i].sub, VEC[i].par, VEC[i].calc, 1'b0);
            check(got_v == VEC[i].ok, "R2..R10 table", $sformatf("vector %0d valid", i), got_v, VEC[i].ok);
            if (VEC[i].ok)
                check(got_rsp == VEC[i].rsp, "R2..R10 table", $sformatf("vector %0d reply", i), got_rsp, VEC[i].rsp);
        end

        // R10 go pulse, jump base, session locked afterwards
        check(got_go && !got_fail, "R10", "go pulse", {got_go, got_fail}, 2'b10);
        check(tgt_base == 24'h0B0000, "R10", "jump base", tgt_base, 24'h0B0000);
        check(!data_en, "R10", "data_en after go", data_en, 0);
        send(8'h34, 8'h80, 40'h04000B0000, 16'h0, 1'b0);
        check(!got_v, "R10", "locked after go", got_v, 0);

        // R5 rejected address leaves tgt_base, R4 base and data_en
        send(8'h31, 8'hA0, 40'h0001000100, 16'h0, 1'b0);
        check(got_v && got_rsp == 48'h7F31A0010000, "R2", "open n=1", got_rsp, 48'h7F31A0010000);
        send(8'h34, 8'h80, 40'h04000B0200, 16'h0, 1'b0);
        check(!got_v && tgt_base == 24'h0B0000, "R5", "off-grid mid", tgt_base, 24'h0B0000);
        send(8'h34, 8'h80, 40'h04000B0800, 16'h0, 1'b0);
        check(tgt_base == 24'h0B0800, "R4", "tgt_base", tgt_base, 24'h0B0800);
        check(data_en, "R4", "data_en", data_en, 1);

        // R6 block full drops data_en
        @(negedge clk); blk_full = 1'b1;
        @(negedge clk); blk_full = 1'b0;
        check(!data_en, "R6", "data_en after full", data_en, 0);

        // R8 counter zero rejection, R11 mismatch
        send(8'h37, 8'h80, 40'h0, 16'h0, 1'b0);
        send(8'h32, 8'hA2, 40'h0, 16'h0, 1'b0);
        check(got_v, "R8", "last block done", got_v, 1);
        send(8'h32, 8'hA2, 40'h0, 16'h0, 1'b0);
        check(!got_v, "R8", "counter at zero", got_v, 0);
        send(8'h31, 8'hA5, 40'hABCD000000, 16'h0, 1'b0);
        check(got_rsp == 48'h7F31A5ABCD00, "R9", "submit reply", got_rsp, 48'h7F31A5ABCD00);
        send(8'h32, 8'hA5, 40'h0, 16'h0000, 1'b0);
        check(got_v && got_rsp == 48'h7F32A5005B63, "R11", "mismatch reply", got_rsp, 48'h7F32A5005B63);
        check(got_fail && !got_go, "R11", "fail pulse", {got_fail, got_go}, 2'b10);
        send(8'h32, 8'hA5, 40'h0, 16'hABCD, 1'b0);
        check(!got_v, "R11", "second verify", got_v, 0);

        // R12 watchdog overrides a frame
        send(8'h31, 8'hA0, 40'h0001000100, 16'h0, 1'b0);
        send(8'h34, 8'h80, 40'h04000B0400, 16'h0, 1'b0);
        send(8'h37, 8'h80, 40'h0, 16'h0, 1'b1);
        check(!got_v, "R12", "frame with wdog", got_v, 0);
        check(!data_en && tgt_base == 24'h0, "R12", "cleared", {data_en, tgt_base}, 0);
        send(8'h34, 8'h80, 40'h04000B0400, 16'h0, 1'b0);
        check(!got_v, "R12", "session gone", got_v, 0);

        // R13 unknown codes
        send(8'h33, 8'hA0, 40'h0001000100, 16'h0, 1'b0);
        check(!got_v, "R13", "unknown opcode", got_v, 0);
        send(8'h31, 8'hA1, 40'h0001000100, 16'h0, 1'b0);
        check(!got_v, "R13", "unknown sub", got_v, 0);

        // R3 wrong fixed byte
        send(8'h31, 8'hA0, 40'h0001000200, 16'h0, 1'b0);
        check(!got_v, "R3", "bad fourth byte", got_v, 0);

        done = 1'b1;
        summary();
    end

endmodule